// File: doc/BRIEF.md
# Level interrupt aggregator

This block merges a parameterised set of interrupt request lines, 32 by default, into a single interrupt line for a processor. It keeps one latched pending bit and one enable bit per source. The output is high whenever at least one source is both pending and enabled. A source's pending bit follows its input level, but it changes only when the input changes: a rising input sets it and a falling input clears it.

Software uses a 32-bit word-addressed register port with separate read and write strobes. Two read offsets report the active sources: one as a count and one as a mask. Three write offsets set enable bits, clear enable bits, and wipe the whole block with one command. Each source also has an assertion counter for debug. A side port selects a source and shows its counter.

Top module: `irq_gather`

## Requirements
- R1: At the clock edge where a source input is first sampled high after being low, that source's pending bit becomes 1.
- R2: At the clock edge where a source input is first sampled low after being high, that source's pending bit becomes 0.
- R3: `irq_out` is 1 exactly when some source is both pending and enabled.
- R4: A read with `bus_rd_en` high at offset 0x00 returns, in the same cycle, the number of sources that are both pending and enabled (0 to 32), zero-extended.
- R5: A read at offset 0x04 returns the mask of sources that are both pending and enabled, with bit i for source i. The raw pending mask is never returned.
- R6: A write of any data to offset 0x08 clears every enable bit and every pending bit at the next edge. If a source edge arrives in the same cycle, the clear takes precedence.
- R7: A write to offset 0x10 sets each enable bit whose data bit is 1. A write to offset 0x0C clears each enable bit whose data bit is 1. Enable bits whose data bit is 0 keep their value.
- R8: Reads at any offset other than 0x00 and 0x04 return zero. Writes to any offset other than 0x08, 0x0C and 0x10 change nothing.
- R9: While `rst_n` is low, pending bits, enable bits, sampled inputs and all assertion counters are zero, so `irq_out`, `bus_rdata` and `dbg_count` read zero.
- R10: The counter of source i increments, wrapping at its width, on every rising edge of that source. This holds whether the source is enabled or not, and also during a clear-all write. `dbg_count` shows the counter of the source selected by `dbg_sel`.
- R11: A pending bit wiped by a clear-all write while its input stays high remains 0 until that input falls and rises again.
- R12: `bus_rdata` is zero in any cycle where `bus_rd_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_src | input | N_SRC (32) | Interrupt request levels, synchronous to clk |
| bus_addr | input | ADDR_W (6) | Byte offset of the register access |
| bus_wr_en | input | 1 | Write strobe, applied at the next edge |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rd_en | input | 1 | Read strobe |
| bus_rdata | output | DATA_W (32) | Read data, combinational |
| irq_out | output | 1 | Aggregated interrupt request |
| dbg_sel | input | SEL_W (5) | Source whose counter is shown |
| dbg_count | output | CNT_W (16) | Assertion counter of the selected source |

## Verification
On every cycle, the bound checker confirms the following. Edges move the pending bits the right way. Clear-all empties both masks and drops the output. Set and clear writes reach exactly the bits written. Idle reads and unmapped reads return zero. A mask read agrees with `irq_out`. The counter values, the ignored writes, the re-arming rule after a clear-all, and the exact count returned at 0x00 depend on history across many cycles. Only the bench's reference model, compared on every clock, can show these.

// File: rtl/irq_gather_pkg.sv
package irq_gather_pkg;
   localparam int OFS_COUNT  = 'h00;
   localparam int OFS_ACTIVE = 'h04;
   localparam int OFS_CLRALL = 'h08;
   localparam int OFS_ENCLR  = 'h0C;
   localparam int OFS_ENSET  = 'h10;

   typedef struct packed {
      logic clr_all;
      logic en_clr;
      logic en_set;
   } wr_cmd_t;
endpackage

// File: rtl/irq_src_latch.sv
module irq_src_latch #(
   parameter int N_SRC = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_SRC-1:0] src_i,
   input  logic             clr_all_i,
   output logic [N_SRC-1:0] pend_o,
   output logic [N_SRC-1:0] rise_o
);
   logic [N_SRC-1:0] src_q;
   logic [N_SRC-1:0] pend_q;
   logic [N_SRC-1:0] fall;

   assign rise_o = src_i & ~src_q;
   assign fall   = ~src_i & src_q;
   assign pend_o = pend_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         src_q  <= '0;
         pend_q <= '0;
      end else begin
         src_q <= src_i;
         if (clr_all_i) pend_q <= '0;
         else           pend_q <= (pend_q | rise_o) & ~fall;
      end
   end
endmodule

// File: rtl/irq_enable_reg.sv
module irq_enable_reg
   import irq_gather_pkg::*;
#(
   parameter int N_SRC  = 32,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  wr_cmd_t           cmd_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic [N_SRC-1:0]  en_o
);
   logic [N_SRC-1:0] en_q;
   logic [N_SRC-1:0] bits;
   logic [N_SRC-1:0] set_m;
   logic [N_SRC-1:0] clr_m;

   assign bits  = wdata_i[N_SRC-1:0];
   assign set_m = cmd_i.en_set ? bits : '0;
   assign clr_m = cmd_i.en_clr ? bits : '0;
   assign en_o  = en_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             en_q <= '0;
      else if (cmd_i.clr_all) en_q <= '0;
      else                    en_q <= (en_q | set_m) & ~clr_m;
   end
endmodule

// File: rtl/irq_event_count.sv
module irq_event_count #(
   parameter int N_SRC        = 32,
   parameter int CNT_W        = 16,
   parameter int SEL_W        = 5,
   parameter bit COUNT_EVENTS = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_SRC-1:0] rise_i,
   input  logic [SEL_W-1:0] sel_i,
   output logic [CNT_W-1:0] count_o
);
   generate
      if (COUNT_EVENTS) begin : g_cnt
         logic [CNT_W-1:0] cnt_q [N_SRC];
         for (genvar i = 0; i < N_SRC; i++) begin : g_src
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n)         cnt_q[i] <= '0;
               else if (rise_i[i]) cnt_q[i] <= cnt_q[i] + 1'b1;
            end
         end
         always_comb begin
            count_o = '0;
            for (int k = 0; k < N_SRC; k++)
               if (sel_i == SEL_W'(k)) count_o = cnt_q[k];
         end
      end else begin : g_nocnt
         logic unused_in;
         assign unused_in = ^{clk, rst_n, rise_i, sel_i};
         assign count_o   = '0;
      end
   endgenerate
endmodule

// File: rtl/irq_readout.sv
module irq_readout
   import irq_gather_pkg::*;
#(
   parameter int N_SRC  = 32,
   parameter int DATA_W = 32,
   parameter int ADDR_W = 6
) (
   input  logic [N_SRC-1:0]  act_i,
   input  logic              rd_en_i,
   input  logic [ADDR_W-1:0] addr_i,
   output logic [DATA_W-1:0] rdata_o
);
   localparam int POP_W = $clog2(N_SRC + 1);

   logic [POP_W-1:0] pop;

   always_comb begin
      pop = '0;
      for (int k = 0; k < N_SRC; k++) pop = pop + POP_W'(act_i[k]);
   end

   always_comb begin
      rdata_o = '0;
      if (rd_en_i) begin
         if (addr_i == ADDR_W'(OFS_COUNT))       rdata_o = DATA_W'(pop);
         else if (addr_i == ADDR_W'(OFS_ACTIVE)) rdata_o = DATA_W'(act_i);
      end
   end
endmodule

// File: rtl/irq_gather.sv
module irq_gather
   import irq_gather_pkg::*;
#(
   parameter int N_SRC        = 32,
   parameter int DATA_W       = 32,
   parameter int ADDR_W       = 6,
   parameter int CNT_W        = 16,
   parameter bit COUNT_EVENTS = 1'b1,
   parameter int SEL_W        = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N_SRC-1:0]  irq_src,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr_en,
   input  logic [DATA_W-1:0] bus_wdata,
   input  logic              bus_rd_en,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              irq_out,
   input  logic [SEL_W-1:0]  dbg_sel,
   output logic [CNT_W-1:0]  dbg_count
);
   generate
      if (N_SRC < 1 || N_SRC > DATA_W) begin : g_bad_nsrc
         $error("irq_gather: N_SRC must lie in 1..DATA_W");
      end
      if (ADDR_W < 5) begin : g_bad_addr
         $error("irq_gather: ADDR_W too narrow for the register window");
      end
      if (CNT_W < 1) begin : g_bad_cnt
         $error("irq_gather: CNT_W must be positive");
      end
   endgenerate

   wr_cmd_t          cmd;
   logic [N_SRC-1:0] pend_w;
   logic [N_SRC-1:0] en_w;
   logic [N_SRC-1:0] rise_w;
   logic [N_SRC-1:0] act_w;

   always_comb begin
      cmd         = '0;
      cmd.clr_all = bus_wr_en && (bus_addr == ADDR_W'(OFS_CLRALL));
      cmd.en_clr  = bus_wr_en && (bus_addr == ADDR_W'(OFS_ENCLR));
      cmd.en_set  = bus_wr_en && (bus_addr == ADDR_W'(OFS_ENSET));
   end

   irq_src_latch #(.N_SRC(N_SRC)) u_latch (
      .clk(clk), .rst_n(rst_n), .src_i(irq_src), .clr_all_i(cmd.clr_all),
      .pend_o(pend_w), .rise_o(rise_w)
   );

   irq_enable_reg #(.N_SRC(N_SRC), .DATA_W(DATA_W)) u_en (
      .clk(clk), .rst_n(rst_n), .cmd_i(cmd), .wdata_i(bus_wdata), .en_o(en_w)
   );

   irq_event_count #(.N_SRC(N_SRC), .CNT_W(CNT_W), .SEL_W(SEL_W),
                     .COUNT_EVENTS(COUNT_EVENTS)) u_cnt (
      .clk(clk), .rst_n(rst_n), .rise_i(rise_w), .sel_i(dbg_sel), .count_o(dbg_count)
   );

   assign act_w   = pend_w & en_w;
   assign irq_out = |act_w;

   irq_readout #(.N_SRC(N_SRC), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_rd (
      .act_i(act_w), .rd_en_i(bus_rd_en), .addr_i(bus_addr), .rdata_o(bus_rdata)
   );
endmodule

// File: rtl/irq_gather_chk.sv
module irq_gather_chk #(
   parameter int N_SRC  = 32,
   parameter int DATA_W = 32,
   parameter int ADDR_W = 6
) (
   input logic              clk,
   input logic              rst_n,
   input logic [N_SRC-1:0]  irq_src,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              bus_wr_en,
   input logic [DATA_W-1:0] bus_wdata,
   input logic              bus_rd_en,
   input logic [DATA_W-1:0] bus_rdata,
   input logic              irq_out,
   input logic [N_SRC-1:0]  pend,
   input logic [N_SRC-1:0]  en
);
   logic [N_SRC-1:0] seen_q;
   logic             wipe, up, dn;
   logic [N_SRC-1:0] wbits;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) seen_q <= '0;
      else        seen_q <= irq_src;
   end

   assign wipe  = bus_wr_en && (bus_addr == ADDR_W'('h08));
   assign up    = bus_wr_en && (bus_addr == ADDR_W'('h10));
   assign dn    = bus_wr_en && (bus_addr == ADDR_W'('h0C));
   assign wbits = bus_wdata[N_SRC-1:0];

   // R1
   rise_sets_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|(irq_src & ~seen_q)) && !wipe |=>
      ((pend & $past(irq_src & ~seen_q)) == $past(irq_src & ~seen_q)));
   // R2
   fall_clears_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
      |(~irq_src & seen_q) |=> ((pend & $past(~irq_src & seen_q)) == '0));
   // R6
   wipe_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wipe |=> (pend == '0) && (en == '0) && !irq_out);
   // R7
   en_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      up |=> ((en & $past(wbits)) == $past(wbits)));
   // R7
   en_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dn |=> ((en & $past(wbits)) == '0));
   // R3
   irq_vs_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_rd_en && (bus_addr == ADDR_W'('h04)) |-> ((bus_rdata != '0) == irq_out));
   // R4
   count_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_rd_en && (bus_addr == ADDR_W'('h00)) |-> (bus_rdata <= DATA_W'(N_SRC)));
   // R8
   unmapped_rd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_rd_en && (bus_addr != ADDR_W'('h00)) && (bus_addr != ADDR_W'('h04))
      |-> (bus_rdata == '0));
   // R12
   idle_rd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_rd_en |-> (bus_rdata == '0));
endmodule

bind irq_gather irq_gather_chk #(.N_SRC(N_SRC), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .irq_src(irq_src), .bus_addr(bus_addr),
   .bus_wr_en(bus_wr_en), .bus_wdata(bus_wdata), .bus_rd_en(bus_rd_en),
   .bus_rdata(bus_rdata), .irq_out(irq_out), .pend(pend_w), .en(en_w)
);

// File: tb/sim_irq_gather.sv
module sim_irq_gather;
   localparam int N = 32, AW = 6, DW = 32, CW = 16, SW = 5;
   localparam logic [N-1:0] ALL = '1;

   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic          rst_n = 1'b0;
   logic [N-1:0]  irq_src = '0;
   logic [AW-1:0] bus_addr = '0;
   logic          bus_wr_en = 1'b0, bus_rd_en = 1'b0;
   logic [DW-1:0] bus_wdata = '0;
   logic [DW-1:0] bus_rdata;
   logic          irq_out;
   logic [SW-1:0] dbg_sel = '0;
   logic [CW-1:0] dbg_count;

   irq_gather #(.N_SRC(N), .DATA_W(DW), .ADDR_W(AW), .CNT_W(CW)) u0 (
      .clk(clk), .rst_n(rst_n), .irq_src(irq_src), .bus_addr(bus_addr),
      .bus_wr_en(bus_wr_en), .bus_wdata(bus_wdata), .bus_rd_en(bus_rd_en),
      .bus_rdata(bus_rdata), .irq_out(irq_out), .dbg_sel(dbg_sel), .dbg_count(dbg_count)
   );

   logic [N-1:0]  m_pend = '0, m_en = '0, m_prev = '0;
   logic [CW-1:0] m_cnt [N];
   int n_chk = 0, n_fail = 0;
   logic [DW-1:0] last_rd;
   logic          last_irq;
   logic [CW-1:0] last_dbg;

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [DW-1:0] exp_rd();
      if (!bus_rd_en) return '0;
      if (bus_addr == AW'('h00)) return DW'($countones(m_pend & m_en));
      if (bus_addr == AW'('h04)) return DW'(m_pend & m_en);
      return '0;
   endfunction

   task automatic step(input logic [N-1:0] s, input bit wr, input logic [AW-1:0] a,
                       input logic [DW-1:0] d, input bit rd, input logic [SW-1:0] sel);
      logic [N-1:0] rise, fall;
      string tag;
      @(negedge clk);
      irq_src = s; bus_wr_en = wr; bus_addr = a; bus_wdata = d; bus_rd_en = rd; dbg_sel = sel;
      #1;
      last_rd = bus_rdata; last_irq = irq_out; last_dbg = dbg_count;
      if (!rd) tag = "R12 idle read";
      else if (a == AW'('h00)) tag = "R4 count read";
      else if (a == AW'('h04)) tag = "R5 mask read";
      else tag = "R8 unmapped read";
      chk(tag, bus_rdata, exp_rd());
      chk("R3 irq_out", irq_out, |(m_pend & m_en));
      chk("R10 dbg_count", dbg_count, m_cnt[sel]);
      @(posedge clk);
      rise = s & ~m_prev;
      fall = ~s & m_prev;
      for (int i = 0; i < N; i++) if (rise[i]) m_cnt[i] = m_cnt[i] + 1'b1;
      m_pend = (m_pend | rise) & ~fall;
      if (wr && a == AW'('h08)) begin m_pend = '0; m_en = '0; end
      else if (wr && a == AW'('h0C)) m_en = m_en & ~d[N-1:0];
      else if (wr && a == AW'('h10)) m_en = m_en | d[N-1:0];
      m_prev = s;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; irq_src = '0; bus_wr_en = 1'b0; bus_rd_en = 1'b1;
      bus_addr = AW'('h04); dbg_sel = SW'(0);
      m_pend = '0; m_en = '0; m_prev = '0;
      for (int i = 0; i < N; i++) m_cnt[i] = '0;
      #1;
      chk("R9 reset irq_out", irq_out, 0);
      chk("R9 reset mask", bus_rdata, 0);
      chk("R9 reset counter", dbg_count, 0);
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
   endtask

   initial begin
      #(200000 * 20);
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      for (int i = 0; i < N; i++) m_cnt[i] = '0;
      do_reset();
      // R1: rise on source 3 with everything enabled
      step('0, 1, 'h10, '1, 0, 0);
      step(32'h8, 0, 0, 0, 0, 3);
      step(32'h8, 0, 'h04, 0, 1, 3);
      chk("R1 pend after rise", last_rd, 32'h8);
      chk("R10 counter src3", last_dbg, 1);
      // R2: fall clears
      step('0, 0, 0, 0, 0, 0);
      step('0, 0, 'h04, 0, 1, 0);
      chk("R2 pend after fall", last_rd, 0);
      // R7: clear upper enables, all sources rise
      step('0, 1, 'h0C, 32'hFFFF_0000, 0, 0);
      step(ALL, 0, 0, 0, 0, 0);
      step(ALL, 0, 'h04, 0, 1, 0);
      chk("R7 w1c mask", last_rd, 32'h0000_FFFF);
      step(ALL, 0, 'h00, 0, 1, 0);
      chk("R4 count 16", last_rd, 16);
      step(ALL, 1, 'h10, 32'h0001_0000, 0, 0);
      step(ALL, 0, 'h04, 0, 1, 0);
      chk("R7 w1s keeps zeros", last_rd, 32'h0001_FFFF);
      // R6 / R11: clear-all with inputs held high
      step(ALL, 1, 'h08, 0, 0, 0);
      step(ALL, 0, 'h04, 0, 1, 0);
      chk("R6 clear-all mask", last_rd, 0);
      chk("R6 clear-all irq", last_irq, 0);
      step(ALL, 1, 'h10, '1, 0, 0);
      step(ALL, 0, 'h04, 0, 1, 0);
      chk("R11 no re-arm while high", last_rd, 0);
      step(ALL & ~32'h1, 0, 0, 0, 0, 0);
      step(ALL, 0, 0, 0, 0, 0);
      step(ALL, 0, 'h04, 0, 1, 0);
      chk("R11 re-arm on new rise", last_rd, 32'h1);
      // R6: clear-all wins over a same-cycle edge; R10 counter still counts
      step(ALL & ~32'h1, 0, 0, 0, 0, 0);
      step(ALL, 1, 'h08, 0, 0, 0);
      step(ALL, 0, 'h04, 0, 1, 0);
      chk("R6 clear beats edge", last_rd, 0);
      chk("R10 counter src0", last_dbg, 3);
      // R8: writes to other offsets are ignored
      step('0, 1, 'h10, 32'hF, 0, 0);
      step(32'hF, 0, 0, 0, 0, 0);
      step(32'hF, 1, 'h04, '1, 0, 0);
      step(32'hF, 1, 'h00, '1, 0, 0);
      step(32'hF, 1, 'h14, '1, 0, 0);
      step(32'hF, 1, 'h3C, '1, 0, 0);
      step(32'hF, 0, 'h04, 0, 1, 0);
      chk("R8 ignored writes", last_rd, 32'hF);
      step(32'hF, 0, 'h14, 0, 1, 0);
      chk("R8 unmapped read", last_rd, 0);
      step(32'hF, 0, 'h04, 0, 0, 0);
      chk("R12 no strobe", last_rd, 0);
      // random traffic against the model
      for (int c = 0; c < 3000; c++) begin
         logic [AW-1:0] a;
         logic [N-1:0]  s;
         bit            wr;
         case ($urandom % 8)
            0: a = 'h00; 1: a = 'h04; 2: a = 'h08; 3: a = 'h0C;
            4: a = 'h10; 5: a = 'h14; 6: a = 'h20; default: a = 'h3C;
         endcase
         wr = ($urandom % 4) == 0;
         if (a == AW'('h08) && ($urandom % 4) != 0) wr = 0;
         s = m_prev ^ ($urandom & $urandom & $urandom);
         step(s, wr, a, $urandom, ($urandom % 4) != 0, SW'($urandom));
      end
      // R9: reset in mid-run
      do_reset();
      step('0, 0, 'h00, 0, 1, 0);
      chk("R9 count after reset", last_rd, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule